// File: doc/BRIEF.md
# Configuration Cycle Address Translator

This block sits between a host bus slave port and a PCIe root-port core. Host accesses that land inside a programmable 64 KB configuration window are turned into configuration requests. The window's lower 32 KB is split into eight 4 KB regions. Each region owns a 16-bit bus/device/function value, and that value becomes the top half of the core address. The offset within the region supplies the register number. A region index of zero yields a Type 0 request and any other region a Type 1 request. Accesses that miss the window, or that fall in its upper half, are answered locally with all-ones data and an error flag.

Reads of the identity dword of device 0, function 0 that come back as all-zeros or all-ones are taken as "not ready yet". The block reissues them after a fixed interval, for a bounded number of times. If every attempt comes back empty, it answers all-ones and raises a not-found flag. A small indexed register port holds the window base and the region values. The core-side transaction is modelled by a request/done handshake that returns one 32-bit data word.

Top module: `cfgwin_xlate`

## Requirements
- R1: After reset, `acc_ready` is 1, `core_req` and `rsp_valid` are 0, and every register index reads back 0.
- R2: Register index 0 holds the window base; only bits 31:16 are stored and bits 15:0 read back as 0. Index k (1..4) reads region 2k-2 in bits 15:0 and region 2k-1 in bits 31:16, and one write to it updates both regions. Other indices read 0 and ignore writes.
- R3: An access is forwarded only if address bits 31:16 equal the base and bit 15 is 0. Any other access raises no `core_req` and is answered one cycle after acceptance with data 0xFFFFFFFF and `rsp_err`=1.
- R4: Address bits 14:12 select the region. `core_addr` is {region value, 4'b0000, access address bits 11:2, 2'b00}.
- R5: `core_type1` is 1 exactly when access address bits 15:12 are non-zero, so region 0 always issues Type 0.
- R6: A forwarded write drives `core_write`=1 and `core_wdata` equal to the host data. It completes with `rsp_err`=0 and `rsp_notfound`=0.
- R7: A forwarded read that is not retried returns `core_rdata` on `rsp_rdata`, in the cycle after `core_done`.
- R8: A read whose address bits 11:2 are zero, whose region value has bits 7:0 zero, and whose data is 0x00000000 or 0xFFFFFFFF is reissued to the same address. Between the two requests `core_req` stays low for exactly `TICKS_PER_MS` cycles.
- R9: Once `RETRY_MAX` reissues have come back empty (`RETRY_MAX`+1 requests in all), the response carries 0xFFFFFFFF with `rsp_notfound`=1 and `rsp_err`=0.
- R10: Empty data on any other read (non-zero dword offset or non-zero device/function) is returned at once without a reissue.
- R11: `acc_ready` is low while an access is in flight. `core_req` holds with a stable `core_addr` until `core_done`, and `rsp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| acc_valid | input | 1 | Host access request |
| acc_write | input | 1 | Host access is a write |
| acc_addr | input | 32 | Host byte address |
| acc_wdata | input | 32 | Host write data |
| acc_ready | output | 1 | Block idle; request accepted when high |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Response data |
| rsp_err | output | 1 | Access was outside the forwarded area |
| rsp_notfound | output | 1 | Identity probe exhausted its retries |
| core_req | output | 1 | Configuration request to the core |
| core_write | output | 1 | Request is a write |
| core_type1 | output | 1 | Request is Type 1 |
| core_addr | output | 32 | Configuration address to the core |
| core_wdata | output | 32 | Configuration write data |
| core_done | input | 1 | Core finished the request |
| core_rdata | input | 32 | Core read data, valid with `core_done` |

## Verification
A corrupted region value or a wrong offset field shows up on `core_addr` in the first cycle of `core_req`, one cycle after acceptance. A wrong Type choice appears on `core_type1` in that same cycle. Errors in the retry counter or the tick counter only appear at the ports as a wrong number of requests, a wrong gap between them, or a missing not-found flag. These take up to (`RETRY_MAX`+1) request round trips to appear, so the bench shrinks both parameters and counts requests and idle cycles on `core_req`. A bad window compare is seen as a missing `rsp_err` pulse one cycle after acceptance, or as a stray `core_req`.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BUSY = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_e;

  // Core address: {bus/dev/fn, reserved zeros, ext reg + reg number, byte bits}
  function automatic logic [31:0] core_addr_f(input logic [15:0] bdf,
                                              input logic [11:0] off);
    return {bdf, 4'h0, off[11:2], 2'b00};
  endfunction

  // Any non-zero region nibble means the request goes past the root bus
  function automatic logic is_type1_f(input logic [3:0] nib);
    return |nib;
  endfunction

  // Identity dword of device 0 / function 0
  function automatic logic probe_f(input logic [15:0] bdf,
                                   input logic [11:0] off);
    return (bdf[7:0] == 8'h00) && (off[11:2] == 10'h000);
  endfunction

  function automatic logic empty_f(input logic [31:0] d);
    return (d == 32'h0000_0000) || (d == 32'hFFFF_FFFF);
  endfunction

endpackage

// File: rtl/cfgwin_regs.sv
module cfgwin_regs #(
  parameter int REGIONS = 8,
  parameter int BDF_W   = 16,
  parameter int IDX_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [IDX_W-1:0]         idx,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  output logic [15:0]              base_hi,
  output logic [REGIONS*BDF_W-1:0] bdf_flat
);
  localparam int PAIRS = REGIONS / 2;

  logic [15:0] base_q;
  logic        unused_lo;

  assign unused_lo = ^wdata[15:0];
  assign base_hi   = base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        base_q <= '0;
    else if (wr && idx == IDX_W'(0))   base_q <= wdata[31:16];
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic [BDF_W-1:0] even_q, odd_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        even_q <= '0;
        odd_q  <= '0;
      end else if (wr && idx == IDX_W'(p + 1)) begin
        even_q <= wdata[BDF_W-1:0];
        odd_q  <= wdata[16 +: BDF_W];
      end
    end
    assign bdf_flat[(2*p)*BDF_W   +: BDF_W] = even_q;
    assign bdf_flat[(2*p+1)*BDF_W +: BDF_W] = odd_q;
  end

  always_comb begin
    rdata = '0;
    if (idx == IDX_W'(0)) rdata = {base_q, 16'h0000};
    for (int p = 0; p < PAIRS; p++) begin
      if (idx == IDX_W'(p + 1))
        rdata = {bdf_flat[(2*p+1)*BDF_W +: BDF_W], bdf_flat[(2*p)*BDF_W +: BDF_W]};
    end
  end

endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
#(
  parameter int REGIONS = 8,
  parameter int BDF_W   = 16
) (
  input  logic [31:0]              addr,
  input  logic [15:0]              base_hi,
  input  logic [REGIONS*BDF_W-1:0] bdf_flat,
  output logic                     hit,
  output logic [31:0]              xaddr,
  output logic                     type1,
  output logic                     probe
);
  localparam int REG_W = (REGIONS > 1) ? $clog2(REGIONS) : 1;

  logic [3:0]       nib;
  logic [REG_W-1:0] region;
  logic [15:0]      bdf_sel;
  logic             in_win, in_lower;
  logic             unused_bits;

  assign unused_bits = ^addr[1:0];
  assign nib      = addr[15:12];
  assign region   = addr[12 +: REG_W];
  assign in_win   = (addr[31:16] == base_hi);
  assign in_lower = ({1'b0, nib} < 5'(REGIONS));
  assign hit      = in_win && in_lower;
  assign bdf_sel  = 16'(bdf_flat[region*BDF_W +: BDF_W]);
  assign xaddr    = core_addr_f(bdf_sel, addr[11:0]);
  assign type1    = is_type1_f(nib);
  assign probe    = probe_f(bdf_sel, addr[11:0]);

endmodule

// File: rtl/cfgwin_seq.sv
module cfgwin_seq
  import cfgwin_pkg::*;
#(
  parameter int TICKS_PER_MS = 125000,
  parameter int RETRY_MAX    = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [31:0] acc_wdata,
  input  logic        dec_hit,
  input  logic [31:0] dec_addr,
  input  logic        dec_type1,
  input  logic        dec_probe,
  input  logic        core_done,
  input  logic [31:0] core_rdata,
  output logic        acc_ready,
  output logic        core_req,
  output logic        core_write,
  output logic        core_type1,
  output logic [31:0] core_addr,
  output logic [31:0] core_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err,
  output logic        rsp_notfound,
  output logic        ev_accept,
  output logic        ev_miss,
  output logic        ev_retry,
  output logic        ev_giveup
);
  localparam int TW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam int RW = $clog2(RETRY_MAX + 1);
  localparam logic [TW-1:0] TLAST = TW'(TICKS_PER_MS - 1);
  localparam logic [RW-1:0] RLAST = RW'(RETRY_MAX);

  seq_state_e  st_q;
  logic [TW-1:0] tick_q;
  logic [RW-1:0] tries_q;
  logic          wr_q, t1_q, probe_q;
  logic [31:0]   addr_q, wdata_q;
  logic          rv_q, err_q, nf_q;
  logic [31:0]   rd_q;
  logic          done_now, empty_probe;

  assign acc_ready   = (st_q == SEQ_IDLE);
  assign ev_accept   = acc_ready && acc_valid && dec_hit;
  assign ev_miss     = acc_ready && acc_valid && !dec_hit;
  assign done_now    = (st_q == SEQ_BUSY) && core_done;
  assign empty_probe = done_now && !wr_q && probe_q && empty_f(core_rdata);
  assign ev_retry    = empty_probe && (tries_q != RLAST);
  assign ev_giveup   = empty_probe && (tries_q == RLAST);

  assign core_req     = (st_q == SEQ_BUSY);
  assign core_write   = wr_q;
  assign core_type1   = t1_q;
  assign core_addr    = addr_q;
  assign core_wdata   = wdata_q;
  assign rsp_valid    = rv_q;
  assign rsp_rdata    = rd_q;
  assign rsp_err      = err_q;
  assign rsp_notfound = nf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      tick_q  <= '0;
      tries_q <= '0;
      wr_q    <= 1'b0;
      t1_q    <= 1'b0;
      probe_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rv_q    <= 1'b0;
      err_q   <= 1'b0;
      nf_q    <= 1'b0;
      rd_q    <= '0;
    end else begin
      rv_q  <= 1'b0;
      err_q <= 1'b0;
      nf_q  <= 1'b0;
      unique case (st_q)
        SEQ_IDLE: begin
          if (ev_accept) begin
            wr_q    <= acc_write;
            t1_q    <= dec_type1;
            probe_q <= dec_probe;
            addr_q  <= dec_addr;
            wdata_q <= acc_wdata;
            tries_q <= '0;
            st_q    <= SEQ_BUSY;
          end else if (ev_miss) begin
            rv_q  <= 1'b1;
            rd_q  <= '1;
            err_q <= 1'b1;
          end
        end
        SEQ_BUSY: begin
          if (ev_retry) begin
            tries_q <= tries_q + 1'b1;
            tick_q  <= '0;
            st_q    <= SEQ_WAIT;
          end else if (ev_giveup) begin
            rv_q <= 1'b1;
            rd_q <= '1;
            nf_q <= 1'b1;
            st_q <= SEQ_IDLE;
          end else if (done_now) begin
            rv_q <= 1'b1;
            rd_q <= wr_q ? 32'h0 : core_rdata;
            st_q <= SEQ_IDLE;
          end
        end
        SEQ_WAIT: begin
          if (tick_q == TLAST) st_q   <= SEQ_BUSY;
          else                 tick_q <= tick_q + 1'b1;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfgwin_xlate.sv
module cfgwin_xlate #(
  parameter int TICKS_PER_MS = 125000,
  parameter int RETRY_MAX    = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [31:0] acc_addr,
  input  logic [31:0] acc_wdata,
  output logic        acc_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err,
  output logic        rsp_notfound,
  output logic        core_req,
  output logic        core_write,
  output logic        core_type1,
  output logic [31:0] core_addr,
  output logic [31:0] core_wdata,
  input  logic        core_done,
  input  logic [31:0] core_rdata
);
  localparam int REGIONS = 8;
  localparam int BDF_W   = 16;

  logic [15:0]              base_hi;
  logic [REGIONS*BDF_W-1:0] bdf_flat;
  logic                     dec_hit, dec_type1, dec_probe;
  logic [31:0]              dec_addr;
  logic                     ev_accept, ev_miss, ev_retry, ev_giveup;

  cfgwin_regs #(.REGIONS(REGIONS), .BDF_W(BDF_W), .IDX_W(3)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
    .rdata(reg_rdata), .base_hi(base_hi), .bdf_flat(bdf_flat)
  );

  cfgwin_decode #(.REGIONS(REGIONS), .BDF_W(BDF_W)) u_dec (
    .addr(acc_addr), .base_hi(base_hi), .bdf_flat(bdf_flat),
    .hit(dec_hit), .xaddr(dec_addr), .type1(dec_type1), .probe(dec_probe)
  );

  cfgwin_seq #(.TICKS_PER_MS(TICKS_PER_MS), .RETRY_MAX(RETRY_MAX)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_wdata(acc_wdata),
    .dec_hit(dec_hit), .dec_addr(dec_addr), .dec_type1(dec_type1), .dec_probe(dec_probe),
    .core_done(core_done), .core_rdata(core_rdata),
    .acc_ready(acc_ready), .core_req(core_req), .core_write(core_write),
    .core_type1(core_type1), .core_addr(core_addr), .core_wdata(core_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .rsp_notfound(rsp_notfound),
    .ev_accept(ev_accept), .ev_miss(ev_miss), .ev_retry(ev_retry), .ev_giveup(ev_giveup)
  );

endmodule

// File: rtl/cfgwin_xlate_chk.sv
module cfgwin_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_ready,
  input logic        core_req,
  input logic        core_done,
  input logic [31:0] core_addr,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        rsp_err,
  input logic        rsp_notfound,
  input logic        ev_accept,
  input logic        ev_miss,
  input logic        ev_retry
);
  a_r11_req_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |-> !acc_ready);

  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    core_req && !core_done |=> core_req && $stable(core_addr));

  a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r3_err_ones: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> (rsp_rdata == 32'hFFFF_FFFF) && !rsp_notfound);

  a_r3_miss_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> !core_req && rsp_valid && rsp_err);

  a_r9_nf_ones: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_notfound |-> (rsp_rdata == 32'hFFFF_FFFF));

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |-> (core_addr[15:12] == 4'h0) && (core_addr[1:0] == 2'b00));

  a_r8_retry_waits: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retry |=> !core_req && !rsp_valid);

  a_r11_accept_req: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> core_req);
endmodule

bind cfgwin_xlate cfgwin_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_ready(acc_ready), .core_req(core_req),
  .core_done(core_done), .core_addr(core_addr), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rsp_notfound(rsp_notfound),
  .ev_accept(ev_accept), .ev_miss(ev_miss), .ev_retry(ev_retry)
);

// File: tb/cfgwin_xlate_test.sv
`timescale 1ns/1ps
module cfgwin_xlate_test;
  localparam int TICKS = 4;
  localparam int RMAX  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [31:0] acc_addr = '0, acc_wdata = '0;
  logic acc_ready, rsp_valid, rsp_err, rsp_notfound;
  logic [31:0] rsp_rdata;
  logic core_req, core_write, core_type1;
  logic [31:0] core_addr, core_wdata;
  logic core_done = 1'b0;
  logic [31:0] core_rdata = '0;

  int vectors = 0, fails = 0;

  always #4 clk = ~clk;

  cfgwin_xlate #(.TICKS_PER_MS(TICKS), .RETRY_MAX(RMAX)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_ready(acc_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rsp_notfound(rsp_notfound),
    .core_req(core_req), .core_write(core_write), .core_type1(core_type1),
    .core_addr(core_addr), .core_wdata(core_wdata),
    .core_done(core_done), .core_rdata(core_rdata)
  );

  // ---------------- core model ----------------
  int          empty_left = 0;
  logic [31:0] empty_val  = '0;
  int          attempts   = 0;
  int          low_cnt    = 0;
  int          last_gap   = -1;
  logic        prev_req   = 1'b0;
  int          lat        = 0;
  logic [31:0] seen_addr;
  logic        seen_t1, seen_wr;
  logic [31:0] seen_wdata;

  function automatic logic [31:0] model_data(input logic [31:0] a);
    return a ^ 32'h5A5A_5A5A;
  endfunction

  always @(negedge clk) begin
    if (core_req && !prev_req) begin
      attempts  <= attempts + 1;
      if (attempts > 0) last_gap <= low_cnt;
      seen_addr  <= core_addr;
      seen_t1    <= core_type1;
      seen_wr    <= core_write;
      seen_wdata <= core_wdata;
    end
    if (core_req) low_cnt <= 0; else low_cnt <= low_cnt + 1;
    prev_req <= core_req;
    if (core_req && !core_done) begin
      if (lat == 2) begin
        lat       <= 0;
        core_done <= 1'b1;
        if (empty_left > 0) begin
          empty_left <= empty_left - 1;
          core_rdata <= empty_val;
        end else begin
          core_rdata <= model_data(core_addr);
        end
      end else begin
        lat <= lat + 1;
      end
    end else begin
      core_done <= 1'b0;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] i, output logic [31:0] d);
    @(negedge clk);
    reg_idx = i;
    #1 d = reg_rdata;
  endtask

  logic [31:0] r_data;
  logic        r_err, r_nf;
  int          r_tries;

  task automatic host(input logic wr, input logic [31:0] a, input logic [31:0] d);
    int start, guard;
    @(negedge clk);
    start = attempts;
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
    check(acc_ready, "R11 ready before accept", {31'd0, acc_ready}, 32'd1);
    @(negedge clk);
    acc_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 2000) begin
      if (!acc_ready == 1'b0 && guard == 0 && core_req) ;
      @(negedge clk);
      guard++;
    end
    check(rsp_valid, "R11 response arrives", {31'd0, rsp_valid}, 32'd1);
    r_data = rsp_rdata; r_err = rsp_err; r_nf = rsp_notfound;
    @(negedge clk);
    r_tries = attempts - start;
    check(!rsp_valid && acc_ready, "R11 rsp single pulse, ready again",
          {30'd0, rsp_valid, acc_ready}, 32'd1);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    logic [31:0] d;
    check(acc_ready && !core_req && !rsp_valid, "R1 idle outputs",
          {29'd0, acc_ready, core_req, rsp_valid}, 32'd4);
    for (int i = 0; i < 5; i++) begin
      reg_read(3'(i), d);
      check(d == 32'h0, "R1 register reset", d, 32'h0);
    end
  endtask

  task automatic t_regs;
    logic [31:0] d;
    reg_write(3'd0, 32'h4001_1234);
    reg_read(3'd0, d);
    check(d == 32'h4001_0000, "R2 base aligned", d, 32'h4001_0000);
    reg_write(3'd1, 32'h0108_0000);
    reg_write(3'd2, 32'h0310_0218);
    reg_read(3'd2, d);
    check(d == 32'h0310_0218, "R2 pair readback", d, 32'h0310_0218);
    reg_write(3'd6, 32'hFFFF_FFFF);
    reg_read(3'd6, d);
    check(d == 32'h0, "R2 unused index", d, 32'h0);
    reg_read(3'd1, d);
    check(d == 32'h0108_0000, "R2 pair after stray write", d, 32'h0108_0000);
  endtask

  task automatic t_miss;
    host(1'b0, 32'h4002_0010, 32'h0);
    check(r_err && r_data == 32'hFFFF_FFFF && r_tries == 0, "R3 outside window",
          r_data, 32'hFFFF_FFFF);
    host(1'b1, 32'h4001_8000, 32'h1234);
    check(r_err && r_tries == 0, "R3 upper half not forwarded",
          {31'd0, r_err}, 32'd1);
  endtask

  task automatic t_type0_read;
    host(1'b0, 32'h4001_0044, 32'h0);
    check(seen_addr == 32'h0000_0044, "R4 region0 addr", seen_addr, 32'h0000_0044);
    check(!seen_t1, "R5 region0 type0", {31'd0, seen_t1}, 32'd0);
    check(r_data == model_data(32'h0000_0044) && !r_err && !r_nf, "R7 read data",
          r_data, model_data(32'h0000_0044));
  endtask

  task automatic t_type1_write;
    host(1'b1, 32'h4001_1104, 32'hDEAD_BEEF);
    check(seen_addr == 32'h0108_0104, "R4 region1 addr", seen_addr, 32'h0108_0104);
    check(seen_t1, "R5 region1 type1", {31'd0, seen_t1}, 32'd1);
    check(seen_wr && seen_wdata == 32'hDEAD_BEEF && !r_err && !r_nf, "R6 write forward",
          seen_wdata, 32'hDEAD_BEEF);
    host(1'b0, 32'h4001_3FFC, 32'h0);
    check(seen_addr == 32'h0310_0FFC && seen_t1, "R4 region3 addr", seen_addr, 32'h0310_0FFC);
  endtask

  task automatic t_probe_ok;
    empty_val = 32'h0; empty_left = 2;
    host(1'b0, 32'h4001_0000, 32'h0);
    check(r_tries == 3, "R8 retried count", 32'(r_tries), 32'd3);
    check(last_gap == TICKS, "R8 retry gap", 32'(last_gap), 32'(TICKS));
    check(seen_addr == 32'h0 && r_data == model_data(32'h0) && !r_nf, "R8 final data",
          r_data, model_data(32'h0));
  endtask

  task automatic t_probe_giveup;
    empty_val = 32'hFFFF_FFFF; empty_left = 100;
    host(1'b0, 32'h4001_0000, 32'h0);
    check(r_tries == RMAX + 1, "R9 attempts", 32'(r_tries), 32'(RMAX + 1));
    check(r_nf && !r_err && r_data == 32'hFFFF_FFFF, "R9 not found",
          r_data, 32'hFFFF_FFFF);
    empty_left = 0;
  endtask

  task automatic t_no_retry;
    empty_val = 32'h0; empty_left = 100;
    host(1'b0, 32'h4001_1000, 32'h0);
    check(r_tries == 1 && r_data == 32'h0 && !r_nf, "R10 nonzero devfn", 32'(r_tries), 32'd1);
    host(1'b0, 32'h4001_0004, 32'h0);
    check(r_tries == 1 && r_data == 32'h0 && !r_nf, "R10 nonzero offset", 32'(r_tries), 32'd1);
    empty_left = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_miss();
    t_type0_read();
    t_type1_write();
    t_probe_ok();
    t_probe_giveup();
    t_no_retry();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule